// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This block gives a small CPU core two hardware instruction breakpoints. The core presents the address of each instruction just before that instruction executes. With the address it gives a strobe that marks the first byte of the instruction, plus a one-bit opcode class. The block compares that address with two programmable match registers, each gated by its own enable bit. When an enabled channel hits, the block raises a request toward a single vector that both channels share. The request does not depend on any priority level or global interrupt mask.

Along with the request, the block registers the value that the core will push as the return address. This value is the matched address advanced by one or by two, depending on the opcode class of the instruction that has not yet executed. Software uses a small register interface to program the match addresses and the enables. The same interface reads and clears a sticky flag that records when both channels hit the same instruction; channel 0 is taken as the winner of such a tie. Matches are suppressed on the first instruction of an interrupt handler.

Top module: `addr_break_unit`

## Requirements
- R1: After a synchronous reset, brk_req is 0, stack_val is 0, both match addresses are 0, both enables are 0 and the tie flag is 0.
- R2: A write with cfg_wr high loads a register on the next rising edge. Select 0 is the channel 0 address, select 1 is the channel 1 address, select 2 holds the enables (bit 0 for channel 0, bit 1 for channel 1) and select 3 is the status. cfg_rdata shows the register chosen by cfg_rsel one edge after cfg_rsel is applied, zero-extended.
- R3: When ins_start is high, isr_first is low and ins_addr equals the address of an enabled channel, brk_req is high for exactly the one cycle after that edge.
- R4: A channel whose enable bit is 0 never causes a request, even when its address matches.
- R5: With ins_start low, no request is raised whatever ins_addr holds. This covers addresses inside an instruction and table-data fetches.
- R6: With isr_first high, no request is raised even on an enabled match. The next strobe with isr_first low matches normally.
- R7: On a request, stack_val becomes ins_addr+2 if plus2_class was 1, or ins_addr+1 otherwise, modulo 2^20.
- R8: stack_val holds its value in every cycle with no request.
- R9: When both enabled channels match the same strobe, only one request is raised and status bit 0 (the tie flag) is set.
- R10: Writing select 3 with bit 0 at 1 clears the tie flag, and writing 0 there leaves it unchanged. A tie in the same cycle as a clear leaves the flag set.
- R11: Channel 1 alone raises the same request output and follows the same stack value rule as channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write register select |
| cfg_wdata | input | 20 | Write data |
| cfg_rsel | input | 2 | Read register select |
| cfg_rdata | output | 20 | Registered read data |
| ins_start | input | 1 | Marks ins_addr as the first byte of the next instruction |
| ins_addr | input | 20 | Address of the instruction about to execute |
| plus2_class | input | 1 | 1 when the pending instruction needs a +2 stacked value |
| isr_first | input | 1 | Marks the first instruction of an interrupt handler |
| brk_req | output | 1 | One-cycle breakpoint request on the shared vector |
| stack_val | output | 20 | Value to stack as the return address, held between requests |

## Verification
The bench checks the suppression paths directly: a disabled channel, a missing strobe and a handler's first instruction must all leave brk_req low and stack_val unchanged. A design that ignored any one of these gates would raise a request and change stack_val. It checks the +1/+2 choice at the top of the address space, where a design that failed to wrap would lose the carry out of bit 19. It drives a tie on both channels and a tie during a status clear, so a design that pulsed twice, or that let the clear win, shows up in the request count or in the status readback. It also drives matches on back-to-back strobes, which catches a design that forces a gap between requests.

// File: rtl/abu_pkg.sv
package abu_pkg;
  localparam int NUM_CH = 2;
  localparam int SEL_W  = $clog2(NUM_CH + 2);
endpackage

// File: rtl/abu_regs.sv
module abu_regs #(
  parameter int AW  = 20,
  parameter int NCH = 2,
  parameter int SW  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_wr,
  input  logic [SW-1:0]          cfg_sel,
  input  logic [AW-1:0]          cfg_wdata,
  input  logic [SW-1:0]          cfg_rsel,
  output logic [AW-1:0]          cfg_rdata,
  input  logic                   tie_set,
  output logic [NCH-1:0][AW-1:0] match_addr,
  output logic [NCH-1:0]         en
);
  localparam logic [SW-1:0] SEL_EN = SW'(NCH);
  localparam logic [SW-1:0] SEL_ST = SW'(NCH + 1);

  logic          tie_q;
  logic [AW-1:0] rd_n;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) match_addr[k] <= '0;
      else if (cfg_wr && cfg_sel == SW'(k)) match_addr[k] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= '0;
      tie_q <= 1'b0;
    end else begin
      if (cfg_wr && cfg_sel == SEL_EN) en <= cfg_wdata[NCH-1:0];
      tie_q <= (tie_q & ~(cfg_wr && cfg_sel == SEL_ST && cfg_wdata[0])) | tie_set;
    end
  end

  always_comb begin
    rd_n = '0;
    for (int k = 0; k < NCH; k++)
      if (cfg_rsel == SW'(k)) rd_n = match_addr[k];
    if (cfg_rsel == SEL_EN) rd_n = AW'(en);
    if (cfg_rsel == SEL_ST) rd_n = AW'(tie_q);
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_n;
  end
endmodule

// File: rtl/abu_match.sv
module abu_match #(
  parameter int AW  = 20,
  parameter int NCH = 2
) (
  input  logic                   ins_start,
  input  logic                   isr_first,
  input  logic [AW-1:0]          ins_addr,
  input  logic [NCH-1:0][AW-1:0] match_addr,
  input  logic [NCH-1:0]         en,
  output logic                   fire,
  output logic                   tie
);
  logic [NCH-1:0] hit;
  logic           qual;

  assign qual = ins_start & ~isr_first;

  for (genvar k = 0; k < NCH; k++) begin : g_cmp
    assign hit[k] = qual & en[k] & (ins_addr == match_addr[k]);
  end

  assign fire = |hit;
  assign tie  = (hit & (hit - NCH'(1))) != '0;
endmodule

// File: rtl/abu_retaddr.sv
module abu_retaddr #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [AW-1:0] ins_addr,
  input  logic          plus2,
  output logic          brk_req,
  output logic [AW-1:0] stack_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req   <= 1'b0;
      stack_val <= '0;
    end else begin
      brk_req <= fire;
      if (fire) stack_val <= ins_addr + (plus2 ? AW'(2) : AW'(1));
    end
  end
endmodule

// File: rtl/addr_break_unit.sv
module addr_break_unit #(
  parameter int AW = 20
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_wr,
  input  logic [abu_pkg::SEL_W-1:0]  cfg_sel,
  input  logic [AW-1:0]              cfg_wdata,
  input  logic [abu_pkg::SEL_W-1:0]  cfg_rsel,
  output logic [AW-1:0]              cfg_rdata,
  input  logic                       ins_start,
  input  logic [AW-1:0]              ins_addr,
  input  logic                       plus2_class,
  input  logic                       isr_first,
  output logic                       brk_req,
  output logic [AW-1:0]              stack_val
);
  localparam int NCH = abu_pkg::NUM_CH;
  localparam int SW  = abu_pkg::SEL_W;

  logic [NCH-1:0][AW-1:0] match_addr;
  logic [NCH-1:0]         en;
  logic                   fire;
  logic                   tie;

  abu_regs #(.AW(AW), .NCH(NCH), .SW(SW)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .tie_set(tie), .match_addr(match_addr), .en(en)
  );

  abu_match #(.AW(AW), .NCH(NCH)) u_match (
    .ins_start(ins_start), .isr_first(isr_first), .ins_addr(ins_addr),
    .match_addr(match_addr), .en(en), .fire(fire), .tie(tie)
  );

  abu_retaddr #(.AW(AW)) u_ret (
    .clk(clk), .rst(rst), .fire(fire), .ins_addr(ins_addr),
    .plus2(plus2_class), .brk_req(brk_req), .stack_val(stack_val)
  );
endmodule

// File: rtl/abu_chk.sv
module abu_chk #(
  parameter int AW  = 20,
  parameter int NCH = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ins_start,
  input logic                   isr_first,
  input logic [AW-1:0]          ins_addr,
  input logic                   plus2_class,
  input logic                   brk_req,
  input logic [AW-1:0]          stack_val,
  input logic [NCH-1:0][AW-1:0] match_addr,
  input logic [NCH-1:0]         en
);
  // R3
  ch0_hit_req_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_start && !isr_first && en[0] && ins_addr == match_addr[0]) |=> brk_req);
  // R11
  ch1_hit_req_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_start && !isr_first && en[1] && ins_addr == match_addr[1]) |=> brk_req);
  // R5
  no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !ins_start |=> !brk_req);
  // R6
  isr_first_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_start && isr_first) |=> !brk_req);
  // R4
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !brk_req);
  // R7
  stack_rule_chk: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> stack_val == AW'($past(ins_addr) + ($past(plus2_class) ? AW'(2) : AW'(1))));
  // R8
  stack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !brk_req |-> $stable(stack_val));
endmodule

bind addr_break_unit abu_chk #(.AW(AW), .NCH(abu_pkg::NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .ins_start(ins_start), .isr_first(isr_first),
  .ins_addr(ins_addr), .plus2_class(plus2_class), .brk_req(brk_req),
  .stack_val(stack_val), .match_addr(match_addr), .en(en)
);

// File: tb/test_addr_break_unit.sv
module test_addr_break_unit;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [1:0]    cfg_rsel = '0;
  logic [AW-1:0] cfg_rdata;
  logic          ins_start = 1'b0;
  logic [AW-1:0] ins_addr = '0;
  logic          plus2_class = 1'b0;
  logic          isr_first = 1'b0;
  logic          brk_req;
  logic [AW-1:0] stack_val;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  addr_break_unit #(.AW(AW)) i_addr_break_unit (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .ins_start(ins_start), .ins_addr(ins_addr), .plus2_class(plus2_class),
    .isr_first(isr_first), .brk_req(brk_req), .stack_val(stack_val)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic [1:0] sel, input logic [AW-1:0] exp, input string req);
    @(negedge clk);
    cfg_rsel = sel;
    @(negedge clk);
    check(req, 32'(cfg_rdata), 32'(exp));
  endtask

  // Drive one strobe; check the request and stack value one edge later.
  task automatic strobe(input logic [AW-1:0] a, input logic p2, input logic isr,
                        input logic exp_req, input logic [AW-1:0] exp_stk, input string req);
    @(negedge clk);
    ins_start = 1'b1; ins_addr = a; plus2_class = p2; isr_first = isr;
    @(negedge clk);
    ins_start = 1'b0; isr_first = 1'b0;
    check({req, " req"}, 32'(brk_req), 32'(exp_req));
    check({req, " stack"}, 32'(stack_val), 32'(exp_stk));
  endtask

  task automatic t_reset();
    check("R1 req", 32'(brk_req), 0);
    check("R1 stack", 32'(stack_val), 0);
    for (int s = 0; s < 4; s++) rd_check(2'(s), '0, "R1 reg");
  endtask

  task automatic t_regs();
    wr(2'd0, 20'h12345);
    wr(2'd1, 20'hABCDE);
    wr(2'd2, 20'h0);
    rd_check(2'd0, 20'h12345, "R2 addr0");
    rd_check(2'd1, 20'hABCDE, "R2 addr1");
    rd_check(2'd2, 20'h0, "R2 en");
  endtask

  task automatic t_disabled();
    strobe(20'h12345, 1'b0, 1'b0, 1'b0, 20'h0, "R4 disabled");
    wr(2'd2, 20'h3);
    rd_check(2'd2, 20'h3, "R2 en both");
  endtask

  task automatic t_plus1();
    strobe(20'h12345, 1'b0, 1'b0, 1'b1, 20'h12346, "R3 R7 plus1");
    @(negedge clk);
    check("R3 single pulse", 32'(brk_req), 0);
    check("R8 hold", 32'(stack_val), 32'h12346);
  endtask

  task automatic t_ch1_plus2();
    strobe(20'hABCDE, 1'b1, 1'b0, 1'b1, 20'hABCE0, "R11 R7 plus2");
  endtask

  task automatic t_nostrobe();
    @(negedge clk);
    ins_start = 1'b0; ins_addr = 20'h12345;
    @(negedge clk);
    check("R5 no strobe req", 32'(brk_req), 0);
    check("R8 hold nostrobe", 32'(stack_val), 32'hABCE0);
    strobe(20'h12344, 1'b0, 1'b0, 1'b0, 20'hABCE0, "R3 miss");
  endtask

  task automatic t_isr();
    strobe(20'h12345, 1'b1, 1'b1, 1'b0, 20'hABCE0, "R6 suppressed");
    strobe(20'h12345, 1'b1, 1'b0, 1'b1, 20'h12347, "R6 next normal");
  endtask

  task automatic t_tie();
    wr(2'd1, 20'h12345);
    rd_check(2'd3, 20'h0, "R9 status before");
    strobe(20'h12345, 1'b1, 1'b0, 1'b1, 20'h12347, "R9 tie");
    @(negedge clk);
    check("R9 one pulse", 32'(brk_req), 0);
    rd_check(2'd3, 20'h1, "R9 status set");
    wr(2'd3, 20'h0);
    rd_check(2'd3, 20'h1, "R10 write0 keeps");
    wr(2'd3, 20'h1);
    rd_check(2'd3, 20'h0, "R10 clear");
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_wdata = 20'h1;
    ins_start = 1'b1; ins_addr = 20'h12345; plus2_class = 1'b0;
    @(negedge clk);
    cfg_wr = 1'b0; ins_start = 1'b0;
    check("R10 tie req", 32'(brk_req), 1);
    rd_check(2'd3, 20'h1, "R10 set beats clear");
    wr(2'd3, 20'h1);
  endtask

  task automatic t_wrap();
    wr(2'd0, 20'hFFFFF);
    strobe(20'hFFFFF, 1'b1, 1'b0, 1'b1, 20'h00001, "R7 wrap plus2");
    @(negedge clk);
    ins_start = 1'b1; ins_addr = 20'hFFFFF; plus2_class = 1'b0;
    @(negedge clk);
    ins_addr = 20'h12345; plus2_class = 1'b0;
    check("R3 b2b first req", 32'(brk_req), 1);
    check("R7 wrap plus1", 32'(stack_val), 32'h00000);
    @(negedge clk);
    ins_start = 1'b0;
    check("R11 b2b second req", 32'(brk_req), 1);
    check("R11 b2b stack", 32'(stack_val), 32'h12346);
    @(negedge clk);
    check("R3 b2b end", 32'(brk_req), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_disabled();
    t_plus1();
    t_ch1_plus2();
    t_nostrobe();
    t_isr();
    t_tie();
    t_wrap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule